// File: doc/BRIEF.md
# Watchdog Reset Timer

This block watches for software that has stopped responding. A free-running counter advances only on the ticks of a slow timing source, nominally 1 MHz. That source is separate from the system clock and is presented here as a one-cycle tick enable in the system clock domain. Software keeps the counter away from its limit by issuing a restart strobe at intervals. If the counter reaches the selected time-out first, the block raises a system-reset request. That request lasts a fixed number of system clocks. The block also sets a sticky flag that records the watchdog as the cause of the reset.

A 3-bit scale select sets the time-out to a power of two. The shortest setting is 2^BASE_LOG2 ticks, which is 16K ticks by default. Each step of the select doubles the time-out, so the longest default setting is 2048K ticks. The select is compared against the running count on every tick, so a new setting applies at once. When the enable input is low, the counter stays at zero and no request can be produced.

Top module: `wdog_reset_timer`

## Requirements
- R1: The counter advances only in system clock cycles where `tick_en` is high. While `tick_en` stays low, no time-out occurs, however long that lasts.
- R2: The time-out is 2^(BASE_LOG2+`scale_sel`) ticks, counted from a cleared counter. The L-th tick times out and clears the counter. `rst_req` rises on the second system clock edge after that tick. With ticks every D clocks, starting at the first edge that sees `wd_enable` high, `rst_req` is first high after 2+(L-1)*D edges.
- R3: A one-cycle `restart` pulse is held pending and clears the counter at the next tick. After the last strobe is sampled at edge a, with continuous ticks, `rst_req` rises after edge a+L+2. Strobes repeated more often than the time-out prevent any request.
- R4: While `wd_enable` is low, the counter is held at zero and no new request starts. Re-enabling counts a full time-out from zero.
- R5: Each `rst_req` pulse is high for exactly PULSE_LEN (default 4) consecutive system clocks.
- R6: `wd_caused` goes high with the rising edge of `rst_req` and stays high after the pulse ends. A `flag_clr` pulse clears it one clock later. A time-out in the same cycle takes priority over the clear.
- R7: When `scale_sel` changes, the count is not cleared. If the count already meets the new limit, the next tick times out.
- R8: After reset, `rst_req` and `wd_caused` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | One-cycle tick from the slow watchdog oscillator |
| wd_enable | input | 1 | Watchdog enable |
| scale_sel | input | SEL_W | Time-out select, limit = 2^(BASE_LOG2+scale_sel) ticks |
| restart | input | 1 | Restart strobe from the watchdog-restart instruction |
| flag_clr | input | 1 | Clears the watchdog-cause flag |
| rst_req | output | 1 | System-reset request pulse |
| wd_caused | output | 1 | Sticky flag: last reset came from the watchdog |

## Verification
A counter that advances on non-tick cycles, or is not cleared by a restart, shows up at the ports as a `rst_req` edge that arrives early. The error is at least one tick per missed or extra increment, measured against the exact edge count expected from the tick spacing. A restart that is lost or applied a tick late moves the rising edge by one or more cycles. A stale limit after a scale change delays the request by up to hundreds of cycles instead of the expected two. Faults in the pulse stretcher or the flag appear within PULSE_LEN+1 clocks of the request as a wrong pulse width or a missing flag.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
   // Highest exponent used by the counter: BASE_LOG2 + (2^SEL_W - 1).
   function automatic int wdt_cnt_bits(input int base_log2, input int sel_w);
      return base_log2 + (1 << sel_w) - 1;
   endfunction

   // Bits needed to hold a count of 0..n.
   function automatic int wdt_hold_bits(input int n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction
endpackage

// File: rtl/wdt_restart_sync.sv
// Holds a restart strobe from the system side until the next slow tick,
// so that the counter is cleared exactly once, on a tick boundary.
module wdt_restart_sync (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_en,
   input  logic enable,
   input  logic restart,
   output logic pend
);
   logic pend_n;

   always_comb begin
      if (!enable)
         pend_n = 1'b0;
      else if (tick_en)
         pend_n = restart;          // consumed now; keep a strobe that arrives now
      else
         pend_n = pend | restart;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend <= 1'b0;
      else        pend <= pend_n;
   end
endmodule

// File: rtl/wdt_counter.sv
// Tick counter with a power-of-two limit that is compared on every tick.
module wdt_counter #(
   parameter int BASE_LOG2 = 14,
   parameter int SEL_W     = 3,
   parameter int CNT_W     = 21
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             enable,
   input  logic [SEL_W-1:0] sel,
   input  logic             clr_pend,
   output logic [CNT_W-1:0] cnt,
   output logic             fire
);
   logic [CNT_W:0]   lim_pow;
   logic [CNT_W-1:0] lim_m1;

   always_comb begin
      lim_pow = (CNT_W+1)'(1) << (BASE_LOG2 + 32'(sel));
      lim_m1  = CNT_W'(lim_pow - (CNT_W+1)'(1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         fire <= 1'b0;
      end else begin
         fire <= 1'b0;
         if (!enable) begin
            cnt <= '0;
         end else if (tick_en) begin
            if (clr_pend) begin
               cnt <= '0;
            end else if (cnt >= lim_m1) begin
               cnt  <= '0;
               fire <= 1'b1;
            end else begin
               cnt <= cnt + CNT_W'(1);
            end
         end
      end
   end
endmodule

// File: rtl/wdt_pulse_stretch.sv
// Stretches the one-cycle time-out event into a reset request and keeps
// a sticky cause flag.
module wdt_pulse_stretch #(
   parameter int PULSE_LEN = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fire,
   input  logic flag_clr,
   output logic req,
   output logic flag
);
   localparam int PW = wdt_pkg::wdt_hold_bits(PULSE_LEN);

   generate
      if (PULSE_LEN == 1) begin : g_single
         logic req_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) req_q <= 1'b0;
            else        req_q <= fire;
         end
         assign req = req_q;
      end else begin : g_count
         logic [PW-1:0] left;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          left <= '0;
            else if (fire)       left <= PW'(PULSE_LEN);
            else if (left != '0) left <= left - PW'(1);
         end
         assign req = (left != '0);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flag <= 1'b0;
      else if (fire)     flag <= 1'b1;
      else if (flag_clr) flag <= 1'b0;
   end
endmodule

// File: rtl/wdog_reset_timer.sv
module wdog_reset_timer #(
   parameter int BASE_LOG2 = 14,
   parameter int SEL_W     = 3,
   parameter int PULSE_LEN = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             wd_enable,
   input  logic [SEL_W-1:0] scale_sel,
   input  logic             restart,
   input  logic             flag_clr,
   output logic             rst_req,
   output logic             wd_caused
);
   localparam int CNT_W = wdt_pkg::wdt_cnt_bits(BASE_LOG2, SEL_W);

   initial begin
      assert (BASE_LOG2 >= 1) else $error("BASE_LOG2 must be at least 1");
      assert (SEL_W >= 1 && SEL_W <= 4) else $error("SEL_W out of range");
      assert (CNT_W <= 62) else $error("counter too wide");
      assert (PULSE_LEN >= 1) else $error("PULSE_LEN must be at least 1");
   end

   logic             pend_q;
   logic [CNT_W-1:0] cnt_q;
   logic             fire_q;

   wdt_restart_sync u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_en (tick_en),
      .enable  (wd_enable),
      .restart (restart),
      .pend    (pend_q)
   );

   wdt_counter #(
      .BASE_LOG2 (BASE_LOG2),
      .SEL_W     (SEL_W),
      .CNT_W     (CNT_W)
   ) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_en  (tick_en),
      .enable   (wd_enable),
      .sel      (scale_sel),
      .clr_pend (pend_q),
      .cnt      (cnt_q),
      .fire     (fire_q)
   );

   wdt_pulse_stretch #(
      .PULSE_LEN (PULSE_LEN)
   ) u_pulse (
      .clk      (clk),
      .rst_n    (rst_n),
      .fire     (fire_q),
      .flag_clr (flag_clr),
      .req      (rst_req),
      .flag     (wd_caused)
   );
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
   parameter int CNT_W     = 21,
   parameter int PULSE_LEN = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick_en,
   input logic             wd_enable,
   input logic             flag_clr,
   input logic             rst_req,
   input logic             wd_caused,
   input logic [CNT_W-1:0] cnt,
   input logic             fire
);
   localparam int SW = wdt_pkg::wdt_hold_bits(PULSE_LEN + 1);

   // Clocks since the last time-out event, saturating past the pulse length.
   logic [SW-1:0] since;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        since <= '0;
      else if (fire)                     since <= SW'(1);
      else if (since != '0 && since <= SW'(PULSE_LEN)) since <= since + SW'(1);
   end

   AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      wd_enable && !tick_en |=> cnt == $past(cnt)) else $error("count moved without tick"); // R1

   AST_DISABLED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !wd_enable |=> cnt == '0) else $error("count not held while disabled"); // R4

   AST_PULSE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> (since != '0 && since <= SW'(PULSE_LEN))) else $error("request outside window"); // R5

   AST_FLAG_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_req) |-> wd_caused) else $error("flag missing at request"); // R6

   AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      flag_clr && !fire |=> !wd_caused) else $error("flag not cleared"); // R6

   AST_FIRE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> wd_caused) else $error("time-out lost to clear"); // R6
endmodule

bind wdog_reset_timer wdt_checker #(
   .CNT_W     (CNT_W),
   .PULSE_LEN (PULSE_LEN)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tick_en   (tick_en),
   .wd_enable (wd_enable),
   .flag_clr  (flag_clr),
   .rst_req   (rst_req),
   .wd_caused (wd_caused),
   .cnt       (cnt_q),
   .fire      (fire_q)
);

// File: tb/tb_wdog_reset_timer.sv
module tb_wdog_reset_timer;
   localparam int BASE_LOG2 = 2;
   localparam int SEL_W     = 3;
   localparam int PULSE_LEN = 4;
   localparam int NVEC      = 11;

   // {scale_sel, tick spacing, expected edges to first rst_req}  (R2)
   localparam int VEC [NVEC][3] = '{
      '{0, 1, 5},  '{1, 1, 9},   '{2, 1, 17},  '{3, 1, 33},
      '{4, 1, 65}, '{5, 1, 129}, '{6, 1, 257}, '{7, 1, 513},
      '{0, 2, 8},  '{1, 3, 23},  '{2, 2, 32}
   };

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             tick_en = 1'b0;
   logic             wd_enable = 1'b0;
   logic [SEL_W-1:0] scale_sel = '0;
   logic             restart = 1'b0;
   logic             flag_clr = 1'b0;
   logic             rst_req;
   logic             wd_caused;

   int n_chk = 0;
   int n_bad = 0;
   int cyc   = 0;

   always #10 clk = ~clk;

   wdog_reset_timer #(
      .BASE_LOG2 (BASE_LOG2),
      .SEL_W     (SEL_W),
      .PULSE_LEN (PULSE_LEN)
   ) dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_en   (tick_en),
      .wd_enable (wd_enable),
      .scale_sel (scale_sel),
      .restart   (restart),
      .flag_clr  (flag_clr),
      .rst_req   (rst_req),
      .wd_caused (wd_caused)
   );

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
         finish_run();
      end
   end

   // Disable, then run with a given select and tick spacing. Returns the
   // number of edges until rst_req is seen, or -1 after limit edges.
   task automatic run_to_req(input int sel, input int div, input int limit, output int edges);
      @(negedge clk);
      wd_enable = 1'b0;
      tick_en   = 1'b1;
      repeat (PULSE_LEN + 2) @(negedge clk);
      scale_sel = SEL_W'(sel);
      wd_enable = 1'b1;
      edges = -1;
      for (int n = 0; n < limit; n++) begin
         tick_en = ((n % div) == 0);
         @(posedge clk);
         @(negedge clk);
         if (rst_req) begin
            edges = n + 1;
            break;
         end
      end
      wd_enable = 1'b0;
      tick_en   = 1'b1;
   endtask

   // Called at the negedge where rst_req was first seen high.
   task automatic pulse_width(output int w);
      w = 1;
      for (int k = 0; k < 20; k++) begin
         @(negedge clk);
         if (!rst_req) break;
         w++;
      end
   endtask

   task automatic clear_flag();
      flag_clr = 1'b1;
      @(negedge clk);
      flag_clr = 1'b0;
   endtask

   initial begin
      int e;
      int w;
      int seen;
      repeat (3) @(negedge clk);
      // R8: reset state
      check("R8 rst_req after reset", int'(rst_req), 0);
      check("R8 wd_caused after reset", int'(wd_caused), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2, R5, R6: table of selects and tick spacings
      for (int v = 0; v < NVEC; v++) begin
         run_to_req(VEC[v][0], VEC[v][1], 1200, e);
         check($sformatf("R2 latency sel=%0d div=%0d", VEC[v][0], VEC[v][1]), e, VEC[v][2]);
         if (e > 0) begin
            check("R6 flag at request", int'(wd_caused), 1);
            pulse_width(w);
            check("R5 pulse width", w, PULSE_LEN);
            check("R6 flag held after pulse", int'(wd_caused), 1);
            clear_flag();
            check("R6 flag cleared", int'(wd_caused), 0);
         end
      end

      // R1: no ticks, no time-out; then counting starts from zero
      @(negedge clk);
      scale_sel = '0;
      tick_en   = 1'b0;
      wd_enable = 1'b1;
      seen = 0;
      for (int k = 0; k < 100; k++) begin
         @(negedge clk);
         if (rst_req) seen = 1;
      end
      check("R1 no request without ticks", seen, 0);
      e = -1;
      for (int n = 0; n < 50; n++) begin
         tick_en = 1'b1;
         @(negedge clk);
         if (rst_req) begin e = n + 1; break; end
      end
      check("R1 latency once ticks resume", e, 5);
      wd_enable = 1'b0;
      repeat (PULSE_LEN + 2) @(negedge clk);
      clear_flag();

      // R4: disabled for a long time with ticks
      seen = 0;
      for (int k = 0; k < 600; k++) begin
         @(negedge clk);
         if (rst_req) seen = 1;
      end
      check("R4 no request while disabled", seen, 0);
      // R4: a short disable mid-count restarts from zero (sel 2, L=16)
      scale_sel = SEL_W'(2);
      wd_enable = 1'b1;
      repeat (10) @(negedge clk);
      wd_enable = 1'b0;
      @(negedge clk);
      wd_enable = 1'b1;
      e = -1;
      for (int n = 0; n < 100; n++) begin
         @(negedge clk);
         if (rst_req) begin e = n + 1; break; end
      end
      check("R4 full time-out after re-enable", e, 17);
      wd_enable = 1'b0;
      repeat (PULSE_LEN + 2) @(negedge clk);
      clear_flag();

      // R3: periodic restart (sel 1, L=8) holds off the request
      scale_sel = SEL_W'(1);
      wd_enable = 1'b1;
      seen = 0;
      for (int k = 0; k < 30; k++) begin
         restart = 1'b1;
         @(negedge clk);
         restart = 1'b0;
         if (rst_req) seen = 1;
         repeat (2) begin
            @(negedge clk);
            if (rst_req) seen = 1;
         end
      end
      check("R3 no request with periodic restart", seen, 0);
      // R3: last strobe at edge a -> request after edge a+L+2 (11 edges)
      restart = 1'b1;
      e = -1;
      for (int n = 0; n < 100; n++) begin
         @(negedge clk);
         restart = 1'b0;
         if (rst_req) begin e = n + 1; break; end
      end
      check("R3 latency after last restart", e, 11);
      wd_enable = 1'b0;
      repeat (PULSE_LEN + 2) @(negedge clk);
      clear_flag();

      // R7: lowering the select mid-count fires at the next tick
      scale_sel = SEL_W'(7);
      wd_enable = 1'b1;
      repeat (20) @(negedge clk);
      check("R7 no request at long select", int'(rst_req), 0);
      scale_sel = '0;
      e = -1;
      for (int n = 0; n < 20; n++) begin
         @(negedge clk);
         if (rst_req) begin e = n + 1; break; end
      end
      check("R7 request two edges after select change", e, 2);
      wd_enable = 1'b0;
      repeat (PULSE_LEN + 2) @(negedge clk);

      // R6: clear and time-out in the same cycle -> flag stays set
      scale_sel = '0;
      wd_enable = 1'b1;
      for (int n = 0; n < 20; n++) begin
         flag_clr = 1'b1;
         @(negedge clk);
         if (rst_req) break;
      end
      flag_clr = 1'b0;
      wd_enable = 1'b0;
      check("R6 time-out wins over clear", int'(wd_caused), 1);

      finish_run();
   end
endmodule